// File: doc/BRIEF.md
# Pipelined SRAM Read Output with Selectable Deselect Depth

This block is the output half of a synchronous pipelined static memory. Every rising clock edge captures a command: a deselect, a read or a write. The command is built from the chip select, the address, the write data and the write controls. A read captured on one edge returns its word on the edge after it, and the pad driver is enabled while that word is presented. Writes go straight into a behavioural array of 36-bit words. The array is split into four 9-bit lanes, and each lane has its own write strobe. A global write fills all four lanes.

A static mode input sets how far a non-read command travels before it shuts the pad driver off. In dual-cycle mode it travels as far as a read, so the driver stays on for one more full cycle. In single-cycle mode it travels one stage less, and the driver turns off just after the edge that captures it. The output-enable and sleep inputs act asynchronously on the driver. Sleep also makes the capture edge ignore new commands, and the array keeps its contents.

The driver controller is a two-state machine. DRV_OFF is the reset state. DRV_ON means the command captured one edge earlier was a read. The transition T_ARM (DRV_OFF to DRV_ON) and the transition T_HOLD (DRV_ON to DRV_ON) are taken when the newly captured command is a read. The transition T_DROP (DRV_ON to DRV_OFF) and the transition T_REST (DRV_OFF to DRV_OFF) are taken on any other command.

Top module: `dsel_pipe_sram`

## Requirements
- R1: After reset, `rd_drive` is 0, and the captured command is a deselect until the first active command is clocked in.
- R2: A read captured on edge k places the addressed word on `rd_data` after edge k+1. If `oe_n` and `sleep` are both low, `rd_drive` is 1 in that cycle.
- R3: Reads captured on consecutive edges, each with a new address, give one word per cycle, and the driver stays on without a gap.
- R4: With `dcd_mode`=1, a non-read command (deselect or write) captured on edge j right after a read leaves `rd_drive` at 1 until edge j+1. `rd_drive` goes to 0 after edge j+1.
- R5: With `dcd_mode`=0, a non-read command captured on edge j drives `rd_drive` to 0 right after edge j. This holds even when the word of the read from edge j-1 is on `rd_data`.
- R6: A write with `byte_en`=1 and `glob_wr`=0 updates only the lanes whose `byte_stb` bit is set. Bit i of `byte_stb` covers `wdata` bits [9i+8:9i], and the other lanes keep their old contents.
- R7: With `glob_wr`=1, a write updates all four lanes, whatever the values of `byte_stb` and `byte_en`.
- R8: `sel`=0 is a deselect. `sel`=1 is a write when `glob_wr` is 1, or when `byte_en` is 1 with at least one strobe set. Otherwise `sel`=1 is a read, which includes `byte_en`=1 with all strobes at 0, and that case leaves the array unchanged.
- R9: `oe_n`=1 forces `rd_drive` to 0 at once without any clock. It does not change `rd_data` or the pipeline.
- R10: While `sleep`=1, `rd_drive` is 0 and captured commands act as deselects, so no write takes place. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcd_mode | input | 1 | 1: dual-cycle deselect, 0: single-cycle deselect (static) |
| sel | input | 1 | Chip select, sampled on the edge |
| addr | input | AW | Word address, sampled on the edge |
| byte_en | input | 1 | Enables lane-strobed writes |
| byte_stb | input | LANES | Per-lane write strobes |
| glob_wr | input | 1 | Writes all lanes |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rd_data | output | LANES*LANE_W | Registered read word |
| rd_drive | output | 1 | Pad driver enable for `rd_data` |

## Verification
The properties assume that `dcd_mode` does not change while a read is in flight, and that `sleep` and `oe_n` are stable across each rising edge. The bench changes all three only at falling edges. It switches mode only after two deselect cycles have emptied the pipeline. Read-back checks compare only addresses that the bench has already written, because the array has no reset.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_state_e;
endpackage

// File: rtl/dsp_cmd_capture.sv
module dsp_cmd_capture
    import dsp_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             sleep,
    input  logic             byte_en,
    input  logic             glob_wr,
    input  logic [LANES-1:0] byte_stb,
    input  logic [AW-1:0]    addr,
    output logic             wr_go,
    output logic [LANES-1:0] wr_mask,
    output cmd_e             s1_cmd,
    output logic [AW-1:0]    s1_addr
);
    cmd_e cmd_c;

    always_comb begin
        wr_go   = sel && !sleep && (glob_wr || (byte_en && (|byte_stb)));
        wr_mask = glob_wr ? {LANES{1'b1}} : byte_stb;
        if (!sel || sleep)
            cmd_c = CMD_DESEL;
        else if (wr_go)
            cmd_c = CMD_WRITE;
        else
            cmd_c = CMD_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_cmd  <= CMD_DESEL;
            s1_addr <= '0;
        end else begin
            s1_cmd  <= cmd_c;
            s1_addr <= addr;
        end
    end

    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (s1_cmd == CMD_DESEL));
    a_r8_unselected_is_desel: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (s1_cmd == CMD_DESEL));
endmodule

// File: rtl/dsp_mem_array.sv
module dsp_mem_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] wmask,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g])
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            if (re)
                rdata[g*LANE_W +: LANE_W] <= lane_mem[raddr];
        end
    end
endmodule

// File: rtl/dsp_drive_ctrl.sv
module dsp_drive_ctrl
    import dsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dcd_mode,
    input  logic oe_n,
    input  logic sleep,
    input  cmd_e s1_cmd,
    output logic drive
);
    drv_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            DRV_OFF: state_d = (s1_cmd == CMD_READ) ? DRV_ON : DRV_OFF; // T_ARM / T_REST
            DRV_ON:  state_d = (s1_cmd == CMD_READ) ? DRV_ON : DRV_OFF; // T_HOLD / T_DROP
            default: state_d = DRV_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DRV_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        logic core_on;
        core_on = (state_q == DRV_ON) && (dcd_mode || (s1_cmd == CMD_READ));
        drive   = core_on && !oe_n && !sleep;
    end

    a_r4_dcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dcd_mode && $past(s1_cmd) == CMD_READ && !oe_n && !sleep) |-> drive);
    a_r3_read_stream: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s1_cmd) == CMD_READ && s1_cmd == CMD_READ && !oe_n && !sleep) |-> drive);
    a_r5_scd_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (!dcd_mode && s1_cmd != CMD_READ) |-> !drive);
    a_r2_on_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DRV_ON) |-> ($past(s1_cmd) == CMD_READ));
endmodule

// File: rtl/dsel_pipe_sram.sv
module dsel_pipe_sram
    import dsp_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dcd_mode,
    input  logic             sel,
    input  logic [AW-1:0]    addr,
    input  logic             byte_en,
    input  logic [LANES-1:0] byte_stb,
    input  logic             glob_wr,
    input  logic [W-1:0]     wdata,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [W-1:0]     rd_data,
    output logic             rd_drive
);
    logic             wr_go;
    logic [LANES-1:0] wr_mask;
    cmd_e             s1_cmd;
    logic [AW-1:0]    s1_addr;

    dsp_cmd_capture #(.AW(AW), .LANES(LANES)) u_cap (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sleep(sleep),
        .byte_en(byte_en), .glob_wr(glob_wr), .byte_stb(byte_stb), .addr(addr),
        .wr_go(wr_go), .wr_mask(wr_mask), .s1_cmd(s1_cmd), .s1_addr(s1_addr)
    );

    dsp_mem_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .we(wr_go), .wmask(wr_mask), .waddr(addr), .wdata(wdata),
        .re(s1_cmd == CMD_READ), .raddr(s1_addr), .rdata(rd_data)
    );

    dsp_drive_ctrl u_drv (
        .clk(clk), .rst_n(rst_n), .dcd_mode(dcd_mode), .oe_n(oe_n),
        .sleep(sleep), .s1_cmd(s1_cmd), .drive(rd_drive)
    );
endmodule

// File: tb/dsel_pipe_sram_tb.sv
module dsel_pipe_sram_tb;
    localparam int CLK_P = 10;
    localparam int W = 36;

    typedef struct {
        logic        drv;
        logic [W-1:0] data;
        string       tag;
    } exp_t;

    logic clk = 0, rst_n = 0, dcd_mode = 1, sel = 0, byte_en = 0, glob_wr = 0;
    logic oe_n = 0, sleep = 0;
    logic [5:0] addr = 0;
    logic [3:0] byte_stb = 0;
    logic [W-1:0] wdata = 0;
    logic [W-1:0] rd_data;
    logic rd_drive;

    int checks = 0, errors = 0;
    exp_t q[$];
    logic [W-1:0] model [64];
    logic prev_read = 0;
    logic [W-1:0] prev_data = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    dsel_pipe_sram u_dut (
        .clk(clk), .rst_n(rst_n), .dcd_mode(dcd_mode), .sel(sel), .addr(addr),
        .byte_en(byte_en), .byte_stb(byte_stb), .glob_wr(glob_wr), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic issue(input logic s, input logic be, input logic gw,
                         input logic [3:0] stb, input int a, input logic [W-1:0] d,
                         input logic oen, input logic slp, input string tag);
        exp_t e;
        int kind; // 0 desel, 1 read, 2 write
        @(negedge clk);
        sel = s; byte_en = be; glob_wr = gw; byte_stb = stb; addr = a[5:0];
        wdata = d; oe_n = oen; sleep = slp;
        if (!s || slp) kind = 0;
        else if (gw || (be && (|stb))) kind = 2;
        else kind = 1;
        e.drv  = prev_read && (dcd_mode || kind == 1) && !oen && !slp;
        e.data = prev_data;
        e.tag  = tag;
        q.push_back(e);
        if (kind == 1) prev_data = model[a];
        if (kind == 2)
            for (int l = 0; l < 4; l++)
                if (gw || stb[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
        prev_read = (kind == 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 0, 0, 4'h0, 0, '0, 0, 0, "R4");
    endtask

    task automatic rd(input int a, input string tag);
        issue(1, 0, 0, 4'h0, a, '0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (rd_drive !== e.drv) begin
                    errors++;
                    $display("FAIL %s drive act=%0b exp=%0b", e.tag, rd_drive, e.drv);
                end
                if (e.drv) begin
                    checks++;
                    if (rd_data !== e.data) begin
                        errors++;
                        $display("FAIL %s data act=%h exp=%h", e.tag, rd_data, e.data);
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=done");
            summary();
        end
    end

    initial begin : main
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_drive !== 1'b0) begin
            errors++;
            $display("FAIL R1 drive in reset act=%0b exp=0", rd_drive);
        end
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (rd_drive !== 1'b0) begin
            errors++;
            $display("FAIL R1 drive after reset act=%0b exp=0", rd_drive);
        end
        // R7: global writes with strobes low
        for (int a = 1; a <= 6; a++)
            issue(1, 0, 1, 4'h0, a, 36'h1_2345_6789 * a, 0, 0, "R7");
        issue(1, 1, 1, 4'h2, 7, 36'hF_0F0F_0F0F, 0, 0, "R7");
        idle(2);
        // R2, R3: single read, then back-to-back reads (DCD)
        rd(1, "R2"); idle(2);
        rd(2, "R3"); rd(3, "R3"); rd(4, "R3"); rd(7, "R3");
        // R4: deselect after read keeps driver one more cycle
        idle(3);
        // R4: write after read in DCD
        rd(5, "R4"); issue(1, 0, 1, 4'h0, 9, 36'hA_AAAA_AAAA, 0, 0, "R4"); idle(2);
        // R6: byte lanes 0 and 2
        issue(1, 1, 0, 4'b0101, 2, 36'h5_5555_5555, 0, 0, "R6");
        issue(1, 1, 0, 4'b1000, 3, 36'hC_CCCC_CCCC, 0, 0, "R6");
        rd(2, "R6"); rd(3, "R6"); idle(2);
        // R8: byte_en with zero strobes is a read, array untouched
        issue(1, 1, 0, 4'h0, 4, 36'hD_EADB_EEF0, 0, 0, "R8");
        rd(4, "R8"); issue(0, 0, 1, 4'hF, 6, 36'h0, 0, 0, "R8");
        rd(6, "R8"); idle(2);
        // R9: output enable gating
        rd(1, "R9"); issue(1, 0, 0, 4'h0, 2, '0, 1, 0, "R9");
        issue(1, 0, 0, 4'h0, 3, '0, 1, 0, "R9"); rd(4, "R9"); idle(2);
        // R10: sleep ignores a write and gates output; contents kept
        rd(5, "R10");
        issue(1, 0, 1, 4'h0, 5, 36'h0_0000_0001, 0, 1, "R10");
        issue(1, 0, 0, 4'h0, 6, '0, 0, 1, "R10");
        rd(5, "R10"); rd(1, "R10"); idle(2);
        // R5: single-cycle deselect mode
        @(negedge clk); dcd_mode = 0;
        rd(1, "R5"); idle(2);
        rd(2, "R5"); rd(3, "R5"); issue(0, 0, 0, 4'h0, 0, '0, 0, 0, "R5");
        rd(4, "R5"); issue(1, 0, 1, 4'h0, 10, 36'h3_3333_3333, 0, 0, "R5");
        rd(10, "R5"); rd(7, "R5"); idle(2);
        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end
endmodule